// File: doc/BRIEF.md
# DMA Stream Width Adapter and Address Sequencer

This block is the data path and pointer logic of one DMA stream whose two ends, a peripheral side and a memory side, each run at 8, 16 or 32 bits. It reads items from one side and writes them to the other. When the read side is narrower it gathers several items into one wider word before writing. When the read side is wider it cuts each word into narrower items. Both address pointers advance after every beat. The block also counts the peripheral items still to move and signals when the stream has finished.

A run begins when a one-cycle `start` arrives while the block is idle. On that edge it samples both base addresses, both width codes, the item count, the direction bit and the fixed-stride bit. Reads and writes are single-beat valid/ready transactions, and only one of them is pending at any time. The payload of a request stays frozen until its ready is seen. A read's data is taken on `rd_data` in the same cycle that `rd_valid` and `rd_ready` are both high. Neither channel buffers anything, so back-pressure on either channel stalls the whole stream.

Top module: `dma_width_packer`

## Requirements
- R1: Width codes are 0 for 8 bits, 1 for 16 bits and 2 for 32 bits, and `item_count` counts peripheral-width items. A start is refused if either code is 3, if the count is zero, or if the peripheral is narrower than memory and the count is not a multiple of the memory/peripheral width ratio. A refused start gives a one-cycle `cfg_err` pulse, and the block stays idle with no request raised.
- R2: Packing is little-endian. Within each gathered word, the k-th narrow item occupies bytes k*w through k*w+w-1, where w is the narrow width in bytes. Splitting hands those bytes out in the same ascending order.
- R3: The memory address starts at `mem_base` and advances by the memory width in bytes after each memory beat. Memory data sits on byte lanes starting at lane mem_addr[1:0]. A memory write asserts exactly those lanes in `wr_strb`.
- R4: With `per_stride4` low, the peripheral address starts at `per_base` and advances by the peripheral width in bytes after each peripheral beat.
- R5: With `per_stride4` high, the peripheral address advances by 4 after every peripheral beat, whatever the peripheral width.
- R6: When reads are narrower than writes, each write is issued only after all reads that fill its word are accepted. When reads are wider, every write taken from a read word is issued before the next read.
- R7: With `dir` = 0 the peripheral side is read and memory written; with `dir` = 1 memory is read and the peripheral side written. `rd_is_mem` and `wr_is_mem` name the port of each request. Peripheral data is right-justified in bit 0 upward, with strobes on the low lanes. Read bytes outside the addressed lanes are ignored.
- R8: A raised `rd_valid` or `wr_valid` holds with a stable address and payload until its ready is sampled high. The two valids are never high together.
- R9: After the write that carries the last item is accepted, `done` is high for exactly one cycle and the block returns to idle. By then there have been `item_count` peripheral beats and count·pw/mw memory beats.
- R10: `busy` is high from an accepted start until the block returns to idle. A `start`, or any configuration change, while busy has no effect on the running stream.
- R11: After reset the block is idle, and `busy`, `done`, `cfg_err`, `rd_valid` and `wr_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a stream when idle |
| dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| per_stride4 | input | 1 | Fixed 4-byte peripheral address step |
| per_size | input | 2 | Peripheral width code |
| mem_size | input | 2 | Memory width code |
| item_count | input | CW | Items to move, in peripheral widths |
| per_base | input | AW | Peripheral start address |
| mem_base | input | AW | Memory start address |
| rd_valid | output | 1 | Read request pending |
| rd_ready | input | 1 | Read accepted, data present |
| rd_addr | output | AW | Read byte address |
| rd_is_mem | output | 1 | Read targets memory side |
| rd_size | output | 2 | Read width code |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write byte address |
| wr_is_mem | output | 1 | Write targets memory side |
| wr_size | output | 2 | Write width code |
| wr_data | output | 32 | Write data |
| wr_strb | output | 4 | Byte-lane enables |
| busy | output | 1 | Stream in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | One-cycle refused-start pulse |

## Verification
The bench builds the block with 32-bit addresses and an 8-bit item counter. That keeps each run short, which makes room to sweep every direction, every pair of width codes and both stride modes, each with two or three item counts. Some runs use memory bases that are not word-aligned, so narrow memory beats land on upper lanes. Both ready lines stall on different repeating patterns, and a stray start is injected into live runs.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;
  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned BUS_W     = BUS_BYTES * 8;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} seq_state_e;

  function automatic logic [BUS_BYTES-1:0] lane_mask(input logic [1:0] lg);
    case (lg)
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] bit_mask(input logic [1:0] lg);
    case (lg)
      2'd0:    bit_mask = 32'h0000_00FF;
      2'd1:    bit_mask = 32'h0000_FFFF;
      default: bit_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic [2:0]    step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base;
    else if (adv)  addr <= addr + AW'(step);
  end
endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack
  import dma_pack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put,
  input  logic [1:0]       put_off,
  input  logic [1:0]       put_lg,
  input  logic [BUS_W-1:0] put_item,
  input  logic [1:0]       get_off,
  input  logic [1:0]       get_lg,
  output logic [BUS_W-1:0] get_item
);
  logic [BUS_W-1:0]     word_q;
  logic [BUS_W-1:0]     item_sh;
  logic [BUS_BYTES-1:0] put_lanes;

  assign item_sh   = put_item << {put_off, 3'b000};
  assign put_lanes = lane_mask(put_lg) << put_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (put) begin
      for (int b = 0; b < BUS_BYTES; b++)
        if (put_lanes[b]) word_q[b*8 +: 8] <= item_sh[b*8 +: 8];
    end
  end

  assign get_item = (word_q >> {get_off, 3'b000}) & bit_mask(get_lg);
endmodule

// File: rtl/dma_pack_seq.sv
module dma_pack_seq
  import dma_pack_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    per_size,
  input  logic [1:0]    mem_size,
  input  logic [CW-1:0] item_count,
  input  logic          dir,
  input  logic          per_stride4,
  input  logic          rd_fire,
  input  logic          wr_fire,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          cfg_err,
  output logic          rd_act,
  output logic          wr_act,
  output logic [1:0]    off,
  output logic [1:0]    rd_lg,
  output logic [1:0]    wr_lg,
  output logic [1:0]    psz_q,
  output logic          dir_q,
  output logic          stride4_q
);
  seq_state_e    st_q;
  logic [2:0]    off_q;
  logic [CW-1:0] cnt_q, cnt_wr_n;
  logic [1:0]    msz_q, chunk_lg;
  logic [2:0]    ratio_mask, off_rd_n, off_wr_n, chunk_bytes;
  logic          cfg_bad, rd_last, wr_last;

  assign ratio_mask = (per_size < mem_size) ? 3'((32'd1 << (mem_size - per_size)) - 32'd1) : 3'd0;
  assign cfg_bad    = (per_size == 2'd3) || (mem_size == 2'd3) || (item_count == '0) ||
                      ((item_count & CW'(ratio_mask)) != '0);
  assign accept     = (st_q == ST_IDLE) && start && !cfg_bad;

  assign chunk_lg    = (psz_q > msz_q) ? psz_q : msz_q;
  assign chunk_bytes = 3'(32'd1 << chunk_lg);
  assign rd_lg       = dir_q ? msz_q : psz_q;
  assign wr_lg       = dir_q ? psz_q : msz_q;
  assign off_rd_n    = off_q + 3'(32'd1 << rd_lg);
  assign off_wr_n    = off_q + 3'(32'd1 << wr_lg);
  assign rd_last     = (off_rd_n == chunk_bytes);
  assign wr_last     = (off_wr_n == chunk_bytes);
  assign cnt_wr_n    = dir_q ? cnt_q - CW'(1) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; off_q <= '0; cnt_q <= '0; done <= 1'b0; cfg_err <= 1'b0;
      psz_q <= '0; msz_q <= '0; dir_q <= 1'b0; stride4_q <= 1'b0;
    end else begin
      done    <= 1'b0;
      cfg_err <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          if (cfg_bad) cfg_err <= 1'b1;
          else begin
            psz_q <= per_size; msz_q <= mem_size; dir_q <= dir; stride4_q <= per_stride4;
            cnt_q <= item_count; off_q <= '0; st_q <= ST_RD;
          end
        end
        ST_RD: if (rd_fire) begin
          if (!dir_q) cnt_q <= cnt_q - CW'(1);
          if (rd_last) begin off_q <= '0; st_q <= ST_WR; end
          else off_q <= off_rd_n;
        end
        ST_WR: if (wr_fire) begin
          cnt_q <= cnt_wr_n;
          if (wr_last) begin
            off_q <= '0;
            if (cnt_wr_n == '0) begin st_q <= ST_IDLE; done <= 1'b1; end
            else st_q <= ST_RD;
          end else off_q <= off_wr_n;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign rd_act = (st_q == ST_RD);
  assign wr_act = (st_q == ST_WR);
  assign off    = off_q[1:0];
endmodule

// File: rtl/dma_width_packer.sv
module dma_width_packer
  import dma_pack_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir,
  input  logic          per_stride4,
  input  logic [1:0]    per_size,
  input  logic [1:0]    mem_size,
  input  logic [CW-1:0] item_count,
  input  logic [AW-1:0] per_base,
  input  logic [AW-1:0] mem_base,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic          rd_is_mem,
  output logic [1:0]    rd_size,
  input  logic [31:0]   rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic          wr_is_mem,
  output logic [1:0]    wr_size,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_strb,
  output logic          busy,
  output logic          done,
  output logic          cfg_err
);
  logic          accept, rd_act, wr_act, rd_fire, wr_fire, dir_q, stride4_q;
  logic [1:0]    off, rd_lg, wr_lg, psz_q, mem_lane;
  logic [AW-1:0] per_addr, mem_addr;
  logic [2:0]    per_step, mem_step;
  logic [BUS_W-1:0] rd_item, slice;

  dma_pack_seq #(.CW(CW)) u_seq (
    .clk, .rst_n, .start, .per_size, .mem_size, .item_count, .dir, .per_stride4,
    .rd_fire, .wr_fire, .accept, .busy, .done, .cfg_err, .rd_act, .wr_act,
    .off, .rd_lg, .wr_lg, .psz_q, .dir_q, .stride4_q
  );

  assign rd_valid = rd_act;
  assign wr_valid = wr_act;
  assign rd_fire  = rd_valid && rd_ready;
  assign wr_fire  = wr_valid && wr_ready;

  assign per_step = stride4_q ? 3'd4 : 3'(32'd1 << psz_q);
  assign mem_step = 3'(32'd1 << (dir_q ? rd_lg : wr_lg));

  dma_ptr #(.AW(AW)) u_per_ptr (
    .clk, .rst_n, .load(accept), .base(per_base),
    .adv(dir_q ? wr_fire : rd_fire), .step(per_step), .addr(per_addr)
  );
  dma_ptr #(.AW(AW)) u_mem_ptr (
    .clk, .rst_n, .load(accept), .base(mem_base),
    .adv(dir_q ? rd_fire : wr_fire), .step(mem_step), .addr(mem_addr)
  );

  assign mem_lane = mem_addr[1:0];
  assign rd_item  = dir_q ? (rd_data >> {mem_lane, 3'b000}) : rd_data;

  dma_lane_pack u_pack (
    .clk, .rst_n, .put(rd_fire), .put_off(off), .put_lg(rd_lg), .put_item(rd_item),
    .get_off(off), .get_lg(wr_lg), .get_item(slice)
  );

  assign rd_addr   = dir_q ? mem_addr : per_addr;
  assign wr_addr   = dir_q ? per_addr : mem_addr;
  assign rd_is_mem = dir_q;
  assign wr_is_mem = !dir_q;
  assign rd_size   = rd_lg;
  assign wr_size   = wr_lg;
  assign wr_data   = dir_q ? slice : (slice << {mem_lane, 3'b000});
  assign wr_strb   = dir_q ? lane_mask(wr_lg) : 4'(lane_mask(wr_lg) << mem_lane);
endmodule

// File: rtl/dma_width_packer_chk.sv
module dma_width_packer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic [3:0]    wr_strb,
  input logic [1:0]    wr_size,
  input logic          done,
  input logic          cfg_err
);
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb));
  p_one_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !rd_valid && !wr_valid);
  p_strb_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $countones(wr_strb) == (1 << wr_size));
endmodule

bind dma_width_packer dma_width_packer_chk #(.AW(AW)) u_chk (
  .clk, .rst_n, .rd_valid, .rd_ready, .rd_addr, .wr_valid, .wr_ready, .wr_addr,
  .wr_data, .wr_strb, .wr_size, .done, .cfg_err
);

// File: tb/tb_dma_width_packer.sv
module tb_dma_width_packer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dir = 1'b0, per_stride4 = 1'b0;
  logic [1:0] per_size = '0, mem_size = '0;
  logic [CW-1:0] item_count = '0;
  logic [AW-1:0] per_base = '0, mem_base = '0;
  logic rd_valid, rd_ready = 1'b0, rd_is_mem, wr_valid, wr_ready = 1'b0, wr_is_mem;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [1:0] rd_size, wr_size;
  logic [31:0] rd_data = '0, wr_data;
  logic [3:0] wr_strb;
  logic busy, done, cfg_err;

  int checks = 0, failures = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_width_packer #(.AW(AW), .CW(CW)) dut (
    .clk, .rst_n, .start, .dir, .per_stride4, .per_size, .mem_size, .item_count,
    .per_base, .mem_base, .rd_valid, .rd_ready, .rd_addr, .rd_is_mem, .rd_size, .rd_data,
    .wr_valid, .wr_ready, .wr_addr, .wr_is_mem, .wr_size, .wr_data, .wr_strb,
    .busy, .done, .cfg_err
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sbyte(input int j, input int seed);
    return 8'((j * 37 + seed * 11 + 5) & 255);
  endfunction

  task automatic run_cfg(input bit d, input int ps, input int ms, input bit f4,
                         input int n, input int seed, input int lane_off, input bit poke);
    int pb, mb, rb, wb, chunk, pstep, rtot, wtot, rk, wi, guard, exp_rd;
    bit fin, both, poked;
    logic [31:0] pbase, mbase, ea, v, ev, em;
    logic [3:0] es;
    pb = 1 << ps; mb = 1 << ms;
    rb = d ? mb : pb; wb = d ? pb : mb;
    chunk = (rb > wb) ? rb : wb;
    pstep = f4 ? 4 : pb;
    rtot = d ? n * pb / mb : n;
    wtot = d ? n : n * pb / mb;
    pbase = 32'h100; mbase = 32'h2000 + lane_off;
    rk = 0; wi = 0; guard = 0; fin = 0; both = 0; poked = 0;
    @(negedge clk);
    dir = d; per_size = 2'(ps); mem_size = 2'(ms); per_stride4 = f4;
    item_count = CW'(n); per_base = pbase; mem_base = mbase; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && guard < 600) begin
      guard++; cyc++;
      start = 1'b0;
      if (done) begin
        chk(wi == wtot, "R9", "write beats at done", 32'(wi), 32'(wtot));
        chk(rk == rtot, "R9", "read beats at done", 32'(rk), 32'(rtot));
        rd_ready = 1'b0; wr_ready = 1'b0; fin = 1;
      end else begin
        if (rd_valid && wr_valid) both = 1;
        rd_ready = (cyc % 3) != 1;
        wr_ready = (cyc % 4) != 2;
        if (poke && rk == 1 && !poked) begin
          // R10: stray start and altered configuration while busy
          chk(busy == 1'b1, "R10", "busy during run", 32'(busy), 32'd1);
          start = 1'b1; item_count = CW'(1); per_size = 2'd2; dir = ~d; per_base = 32'h0;
          poked = 1;
        end
        if (rd_valid && rd_ready) begin
          ea = d ? mbase + 32'(rk * mb) : pbase + 32'(rk * pstep);
          chk(rd_addr == ea, d ? "R3" : (f4 ? "R5" : "R4"), "read address", rd_addr, ea);
          chk(rd_is_mem == d, "R7", "read port", 32'(rd_is_mem), 32'(d));
          v = 32'hA5C3_5A3C ^ 32'(cyc);
          for (int b = 0; b < rb; b++) begin
            int lane;
            lane = d ? int'(rd_addr[1:0]) + b : b;
            v[lane*8 +: 8] = sbyte(rk * rb + b, seed);
          end
          rd_data = v;
          rk++;
        end
        if (wr_valid && wr_ready) begin
          ea = d ? pbase + 32'(wi * pstep) : mbase + 32'(wi * mb);
          chk(wr_addr == ea, d ? (f4 ? "R5" : "R4") : "R3", "write address", wr_addr, ea);
          chk(wr_is_mem == !d, "R7", "write port", 32'(wr_is_mem), 32'(!d));
          ev = '0; em = '0; es = '0;
          for (int b = 0; b < wb; b++) begin
            int lane;
            lane = d ? b : int'(wr_addr[1:0]) + b;
            ev[lane*8 +: 8] = sbyte(wi * wb + b, seed);
            em[lane*8 +: 8] = 8'hFF;
            es[lane] = 1'b1;
          end
          chk((wr_data & em) == ev, "R2", "write data lanes", wr_data & em, ev);
          chk(wr_strb == es, "R3", "write strobes", 32'(wr_strb), 32'(es));
          exp_rd = ((wi * wb) / chunk + 1) * chunk / rb;
          chk(rk == exp_rd, "R6", "reads before write", 32'(rk), 32'(exp_rd));
          wi++;
        end
        @(negedge clk);
      end
    end
    if (!fin) chk(1'b0, "R9", "run timed out", 32'(guard), 32'd0);
    chk(!both, "R8", "both valids high", 32'(both), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", 32'(done), 32'd0);
    chk(busy == 1'b0, "R10", "busy after done", 32'(busy), 32'd0);
  endtask

  task automatic bad_start(input int ps, input int ms, input int n);
    @(negedge clk);
    dir = 1'b0; per_size = 2'(ps); mem_size = 2'(ms); item_count = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 1'b1, "R1", "cfg_err raised", 32'(cfg_err), 32'd1);
    chk(busy == 1'b0 && rd_valid == 1'b0, "R1", "no run after bad start",
        32'({busy, rd_valid}), 32'd0);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R1", "cfg_err one cycle", 32'(cfg_err), 32'd0);
    chk(rd_valid == 1'b0 && wr_valid == 1'b0, "R1", "no request", 32'({rd_valid, wr_valid}), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(busy == 0 && done == 0 && cfg_err == 0, "R11", "status after reset",
        32'({busy, done, cfg_err}), 32'd0);
    chk(rd_valid == 0 && wr_valid == 0, "R11", "valids after reset",
        32'({rd_valid, wr_valid}), 32'd0);
    bad_start(0, 2, 6);
    bad_start(1, 2, 0);
    bad_start(3, 0, 4);
    bad_start(0, 1, 3);
    for (int d = 0; d < 2; d++)
      for (int ps = 0; ps < 3; ps++)
        for (int ms = 0; ms < 3; ms++)
          for (int f4 = 0; f4 < 2; f4++) begin
            int mbb;
            mbb = 1 << ms;
            seed++;
            run_cfg(d[0], ps, ms, f4[0], 4, seed, 0, 1'b0);
            seed++;
            run_cfg(d[0], ps, ms, f4[0], 8, seed, (mbb < 4) ? mbb : 0, 1'b1);
            if (ps > ms) begin
              seed++;
              run_cfg(d[0], ps, ms, f4[0], 3, seed, 0, 1'b0);
            end
          end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule